// File: doc/BRIEF.md
# Load-Store Execution Unit with Acknowledge Handshake

This unit carries out memory loads and stores for the execute stage of a small in-order core. The pipeline gives it a one-cycle start pulse together with the operation kind, an effective address already formed by the shared ALU, the store data and the index of the destination register. The unit then issues a single request to the data bus. It waits as long as needed for an acknowledgement that carries a pass or fail status and, for a load, the read data. Finally it reports the outcome to the pipeline.

A load that passes returns its data through a one-cycle register-file write. A store that passes retires without touching the register file. A failed access of either kind drops any returned data and raises an exception strobe instead of a write. The unit holds the pipeline stalled while the access is outstanding. It marks the shared ALU as occupied only in the request cycle, so the ALU can serve other work while the unit waits.

Top module: `lsu_ack_unit`

## Requirements
- R1: After synchronous reset, bus_req, alu_busy, stall, done, exc and rf_we are all 0.
- R2: A start seen while idle makes bus_req high for exactly one cycle, in the cycle after the start. In that cycle bus_addr and bus_wdata equal the eff_addr and store_data given with the start, and bus_we equals op_store (1 = store, 0 = load).
- R3: alu_busy is high in the request cycle and low in every other cycle.
- R4: stall is high from the request cycle through the cycle in which the acknowledgement is presented. It is low in the cycle in which done or exc is reported.
- R5: The acknowledgement may arrive any number N of cycles (N ≥ 1) after the request. ack_err and ack_rdata have no effect while ack_valid is low, and nothing completes before ack_valid is seen.
- R6: A load acknowledged with ack_err = 0 raises done and rf_we for one cycle, in the cycle after the acknowledgement, with rf_idx equal to the start's dest_idx and rf_wdata equal to ack_rdata.
- R7: A store acknowledged with ack_err = 0 raises done for one cycle, in the cycle after the acknowledgement, with rf_we low.
- R8: Any acknowledgement with ack_err = 1, for a load or a store, raises exc for one cycle in the cycle after it, with done and rf_we low.
- R9: A start pulse while a request is outstanding or being reported is ignored: no further request is issued and the result reported belongs to the first start.
- R10: After done or exc the unit is idle again and accepts the next start.
- R11: ack_valid high while the unit is idle, in its request cycle or in its reporting cycle is ignored and produces no done or exc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (taken only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| eff_addr | input | AW | Effective address from the shared ALU |
| store_data | input | DW | Data to store |
| dest_idx | input | RIW | Destination register index for a load |
| bus_req | output | 1 | One-cycle request strobe to the data bus |
| bus_we | output | 1 | 1 = write access |
| bus_addr | output | AW | Request address |
| bus_wdata | output | DW | Request write data |
| ack_valid | input | 1 | Acknowledgement strobe from the bus |
| ack_err | input | 1 | Acknowledgement status, 1 = failure |
| ack_rdata | input | DW | Read data returned with the acknowledgement |
| alu_busy | output | 1 | Shared ALU occupied by this unit |
| stall | output | 1 | Pipeline must hold |
| done | output | 1 | Access retired successfully |
| exc | output | 1 | Access failed, exception to system control |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | RIW | Register-file write index |
| rf_wdata | output | DW | Register-file write data |

## Verification
If the control state went wrong, it would show at the bus within a cycle. A missing or repeated request would appear as bus_req high for the wrong number of cycles. A misplaced wait would make stall drop before any acknowledgement arrived. If the unit sampled the acknowledgement outside the wait state, a spurious done or exc would appear one cycle after the stray ack_valid. Corrupted captured operands would show on bus_addr or bus_wdata in the request cycle, or on rf_idx in the reporting cycle. The same bad state can also surface later, at completion, as done and exc in the wrong combination or rf_we on a store or a failed load.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lsu_state_e;

  typedef struct packed {
    logic ok;
    logic fail;
    logic wr;
  } lsu_flags_t;
endpackage

// File: rtl/lsu_fsm.sv
`timescale 1ns/1ps
module lsu_fsm
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ack_valid,
  output lsu_state_e state,
  output logic       accept,
  output logic       ack_take
);
  lsu_state_e nxt;

  assign accept   = (state == ST_IDLE) && start;
  assign ack_take = (state == ST_WAIT) && ack_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start)     nxt = ST_REQ;
      ST_REQ:                 nxt = ST_WAIT;
      ST_WAIT: if (ack_valid) nxt = ST_DONE;
      ST_DONE:                nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R2
  req_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REQ) |=> (state == ST_WAIT));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> (state != ST_REQ));
endmodule

// File: rtl/lsu_req_hold.sv
`timescale 1ns/1ps
module lsu_req_hold #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           accept,
  input  logic           op_store,
  input  logic [AW-1:0]  eff_addr,
  input  logic [DW-1:0]  store_data,
  input  logic [RIW-1:0] dest_idx,
  output logic           we_q,
  output logic [AW-1:0]  addr_q,
  output logic [DW-1:0]  wdata_q,
  output logic [RIW-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      we_q    <= op_store;
      addr_q  <= eff_addr;
      wdata_q <= store_data;
      idx_q   <= dest_idx;
    end
  end
endmodule

// File: rtl/lsu_result.sv
`timescale 1ns/1ps
module lsu_result
  import lsu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ack_take,
  input  logic           ack_err,
  input  logic [DW-1:0]  ack_rdata,
  input  logic           is_store,
  input  logic [RIW-1:0] idx,
  output logic           done,
  output logic           exc,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata
);
  lsu_flags_t nf, fq;

  always_comb begin
    nf.ok   = ack_take && !ack_err;
    nf.fail = ack_take &&  ack_err;
    nf.wr   = ack_take && !ack_err && !is_store;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fq       <= '0;
      rf_idx   <= '0;
      rf_wdata <= '0;
    end else begin
      fq <= nf;
      if (nf.wr) begin
        rf_idx   <= idx;
        rf_wdata <= ack_rdata;
      end
    end
  end

  assign done  = fq.ok;
  assign exc   = fq.fail;
  assign rf_we = fq.wr;

  // R8
  done_exc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && exc));

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
endmodule

// File: rtl/lsu_ack_unit.sv
`timescale 1ns/1ps
module lsu_ack_unit
  import lsu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           op_store,
  input  logic [AW-1:0]  eff_addr,
  input  logic [DW-1:0]  store_data,
  input  logic [RIW-1:0] dest_idx,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic           ack_valid,
  input  logic           ack_err,
  input  logic [DW-1:0]  ack_rdata,
  output logic           alu_busy,
  output logic           stall,
  output logic           done,
  output logic           exc,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata
);
  lsu_state_e     state;
  logic           accept;
  logic           ack_take;
  logic [RIW-1:0] idx_q;

  lsu_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ack_valid (ack_valid),
    .state     (state),
    .accept    (accept),
    .ack_take  (ack_take)
  );

  lsu_req_hold #(.AW(AW), .DW(DW), .RIW(RIW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .op_store   (op_store),
    .eff_addr   (eff_addr),
    .store_data (store_data),
    .dest_idx   (dest_idx),
    .we_q       (bus_we),
    .addr_q     (bus_addr),
    .wdata_q    (bus_wdata),
    .idx_q      (idx_q)
  );

  lsu_result #(.DW(DW), .RIW(RIW)) u_res (
    .clk       (clk),
    .rst       (rst),
    .ack_take  (ack_take),
    .ack_err   (ack_err),
    .ack_rdata (ack_rdata),
    .is_store  (bus_we),
    .idx       (idx_q),
    .done      (done),
    .exc       (exc),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .rf_wdata  (rf_wdata)
  );

  assign bus_req  = (state == ST_REQ);
  assign alu_busy = (state == ST_REQ);
  assign stall    = (state == ST_REQ) || (state == ST_WAIT);

  // R2
  req_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(start));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> !bus_req);

  // R4
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> (done || exc));

  // R5
  finish_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (done || exc) |-> $past(ack_valid));

  // R7
  load_only_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (done && !bus_we));
endmodule

// File: tb/sim_lsu_ack_unit.sv
`timescale 1ns/1ps
module sim_lsu_ack_unit;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int RIW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst;
  logic           start;
  logic           op_store;
  logic [AW-1:0]  eff_addr;
  logic [DW-1:0]  store_data;
  logic [RIW-1:0] dest_idx;
  logic           bus_req, bus_we;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic           ack_valid, ack_err;
  logic [DW-1:0]  ack_rdata;
  logic           alu_busy, stall, done, exc, rf_we;
  logic [RIW-1:0] rf_idx;
  logic [DW-1:0]  rf_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  lsu_ack_unit #(.AW(AW), .DW(DW), .RIW(RIW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_store(op_store),
    .eff_addr(eff_addr), .store_data(store_data), .dest_idx(dest_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ack_valid(ack_valid), .ack_err(ack_err), .ack_rdata(ack_rdata),
    .alu_busy(alu_busy), .stall(stall), .done(done), .exc(exc),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata)
  );

  function automatic bit exp_done(bit er);
    return !er;
  endfunction

  function automatic bit exp_write(bit st, bit er);
    return !st && !er;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [RIW-1:0] ix, input int lat, input bit er,
                        input logic [DW-1:0] rd, input bit poke);
    @(negedge clk);
    start = 1'b1; op_store = st; eff_addr = a; store_data = d; dest_idx = ix;
    @(negedge clk);
    start = 1'b0; eff_addr = $urandom; store_data = $urandom;
    chk("R2 req high", 64'(bus_req), 64'd1);
    chk("R2 addr", 64'(bus_addr), 64'(a));
    chk("R2 we", 64'(bus_we), 64'(st));
    if (st) chk("R2 wdata", 64'(bus_wdata), 64'(d));
    chk("R3 alu busy in req", 64'(alu_busy), 64'd1);
    chk("R4 stall in req", 64'(stall), 64'd1);
    if (poke) begin ack_valid = 1'b1; ack_err = 1'b1; end
    for (int i = 1; i < lat; i++) begin
      @(negedge clk);
      ack_valid = 1'b0; ack_err = 1'($urandom); ack_rdata = $urandom;
      if (poke) begin start = 1'b1; dest_idx = ~ix; end
      chk("R2 req single", 64'(bus_req), 64'd0);
      chk("R3 alu free in wait", 64'(alu_busy), 64'd0);
      chk("R4 stall in wait", 64'(stall), 64'd1);
      chk("R5 no early done", 64'(done), 64'd0);
      chk("R11 no early exc", 64'(exc), 64'd0);
    end
    @(negedge clk);
    start = 1'b0; ack_valid = 1'b1; ack_err = er; ack_rdata = rd;
    chk("R4 stall at ack", 64'(stall), 64'd1);
    chk("R9 no second req", 64'(bus_req), 64'd0);
    @(negedge clk);
    ack_valid = 1'b0; ack_err = 1'($urandom); ack_rdata = $urandom;
    chk(st ? "R7 done" : "R6 done", 64'(done), 64'(exp_done(er)));
    chk("R8 exc", 64'(exc), 64'(er));
    chk("R6 rf_we", 64'(rf_we), 64'(exp_write(st, er)));
    if (exp_write(st, er)) begin
      chk("R6 rf_idx", 64'(rf_idx), 64'(ix));
      chk("R6 rf_wdata", 64'(rf_wdata), 64'(rd));
    end
    chk("R4 stall low at report", 64'(stall), 64'd0);
    if (poke) begin
      start = 1'b1; dest_idx = ~ix; ack_valid = 1'b1; ack_err = 1'b0;
    end
    @(negedge clk);
    start = 1'b0; ack_valid = 1'b0;
    chk("R10 done pulse", 64'(done), 64'd0);
    chk("R8 exc pulse", 64'(exc), 64'd0);
    chk("R6 we pulse", 64'(rf_we), 64'd0);
    chk("R9 start in report ignored", 64'(bus_req), 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; op_store = 1'b0; eff_addr = '0; store_data = '0;
    dest_idx = '0; ack_valid = 1'b0; ack_err = 1'b0; ack_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 req", 64'(bus_req), 64'd0);
    chk("R1 alu", 64'(alu_busy), 64'd0);
    chk("R1 stall", 64'(stall), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 exc", 64'(exc), 64'd0);
    chk("R1 we", 64'(rf_we), 64'd0);

    // R11: stray acknowledgement while idle
    @(negedge clk); ack_valid = 1'b1; ack_err = 1'b1;
    @(negedge clk); ack_valid = 1'b0;
    chk("R11 idle ack exc", 64'(exc), 64'd0);
    chk("R11 idle ack done", 64'(done), 64'd0);

    // directed corners
    do_txn(1'b0, 32'h1000_0004, 32'h0, 5'd3,  1, 1'b0, 32'hCAFE_F00D, 1'b0); // R6 N=1
    do_txn(1'b1, 32'h2000_0010, 32'hDEAD_BEEF, 5'd7, 1, 1'b0, 32'h0, 1'b0);  // R7
    do_txn(1'b0, 32'h0000_0040, 32'h0, 5'd9,  4, 1'b1, 32'h1234_5678, 1'b0); // R8 load
    do_txn(1'b1, 32'h0000_0080, 32'h5555_AAAA, 5'd1, 3, 1'b1, 32'h0, 1'b0);  // R8 store
    do_txn(1'b0, 32'hFFFF_FFFC, 32'h0, 5'd31, 5, 1'b0, 32'hFFFF_FFFF, 1'b1); // R9 R11
    do_txn(1'b0, 32'h0000_0100, 32'h0, 5'd0,  2, 1'b0, 32'h0BAD_0001, 1'b0); // R10

    for (int k = 0; k < 60; k++) begin
      bit st, er, pk;
      int lat;
      st  = 1'($urandom);
      er  = (($urandom % 4) == 0);
      pk  = (($urandom % 3) == 0);
      lat = 1 + int'($urandom % 7);
      do_txn(st, $urandom, $urandom, RIW'($urandom), lat, er, $urandom, pk);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule